// File: doc/BRIEF.md
# Serial Lane Training Engine

This block calibrates one source-synchronous serial lane so that the 12-bit words it delivers are correctly sampled and correctly framed. It runs entirely in the word-clock domain. The serial capture primitive and the programmable input delay line sit outside it. The engine drives the delay line's tap selection and receives the raw parallel words captured through it. In the intended system the bit rate is 300 Mbit/s per lane: a 150 MHz sampling clock, a 25 MHz word clock and a 1:12 deserialization ratio.

Calibration has two phases, and each has its own start command. The first phase is bit correction. It walks the delay tap upward from zero and lets the lane settle after every step. It then compares the word captured at each tap with the word captured at the tap before. The first tap at which the word changes marks the edge of the data eye. The sampling tap is then parked half a nominal eye width beyond that edge. The second phase is word correction. It tries each barrel rotation of the captured word, one per word, until the result equals the training word supplied on an input port (normally 12'h98E). It reports the rotation it found, and it raises an ok status when both phases succeeded.

Once the lane is trained, captured words flow out rotated. Both streams use valid/ready. The input ready is held high while the lane is untrained, because training never stalls the capture. Once trained, the engine holds one output word. While that word is valid and not taken, the output data stays frozen and the input ready is low. Any input word presented while ready is low is not consumed.

Top module: `lane_train_engine`

## Requirements
- R1: After reset, the tap select, eye-start tap, eye-middle tap and rotation count are 0; both done flags, ok, raw_ready-unrelated output valid (cal_valid) are low, and raw_ready is high.
- R2: After bit_start, the tap steps by one from 0 to 31. At each tap the engine skips SETTLE_WORDS valid words and samples the next valid word. eye_start is the first tap t ≥ 1 whose sample differs from the sample at tap t−1.
- R3: At the end of bit correction, eye_mid equals eye_start + HALF_EYE saturated at 31, tap_sel equals eye_mid, and bit_done is high.
- R4: If no sample changes across the whole sweep, eye_start reads 0, eye_mid reads HALF_EYE, and the following word correction leaves ok low.
- R5: After word_start, the engine reports in rot_count the smallest r in 0..11 for which the captured word rotated left by r (bit i moves to bit (i+r) mod 12) equals train_word. word_done rises, and ok rises if bit correction found an edge.
- R6: If no rotation in 0..11 matches, word_done still rises, ok is low and rot_count reads 0.
- R7: cal_valid stays low until word correction ends with ok. After that, a raw word accepted on a clock edge appears rotated left by rot_count on cal_data, with cal_valid high, right after that edge.
- R8: While cal_valid is high and cal_ready is low, cal_data and cal_valid hold and raw_ready is low. raw_ready is high whenever the lane is not trained.
- R9: A bit_start clears bit_done on the following edge, and a word_start clears word_done and ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low reset |
| train_word | input | 12 | Known pattern the lane sends during training |
| bit_start | input | 1 | Pulse: begin the tap sweep |
| word_start | input | 1 | Pulse: begin the rotation search |
| raw_valid | input | 1 | Captured word is present |
| raw_ready | output | 1 | Engine consumes the captured word |
| raw_data | input | 12 | Captured word from the lane |
| tap_sel | output | 5 | Tap select to the delay line |
| eye_start | output | 5 | Tap at which the edge was found |
| eye_mid | output | 5 | Tap chosen for sampling |
| rot_count | output | 4 | Rotation that frames the word |
| bit_done | output | 1 | Bit correction finished |
| word_done | output | 1 | Word correction finished |
| ok | output | 1 | Lane calibrated successfully |
| cal_valid | output | 1 | Calibrated word present |
| cal_ready | input | 1 | Downstream accepts the calibrated word |
| cal_data | output | 12 | Rotated, calibrated word |

## Verification
The hard case is a lane whose eye edge lies near the top of the tap range. There, only a sweep almost to tap 31, with gaps in raw_valid stretching every settle period, can reveal the edge, and the middle tap must saturate. The bench drives a lane model in which the captured word depends on the current tap. Below a chosen edge tap the model returns a corrupted word, and from the edge upward it returns the training word with a random bit slip. The edge tap, the slip and the training word are drawn from $urandom, with directed cases for an edge at tap 30, no edge at all, and a word that no rotation can match.

// File: rtl/lane_train_pkg.sv
package lane_train_pkg;
  typedef enum logic [1:0] {SW_IDLE, SW_SETTLE, SW_SAMPLE} sweep_state_t;
  typedef enum logic {AL_IDLE, AL_TRY} align_state_t;
endpackage

// File: rtl/lane_rotator.sv
module lane_rotator #(
  parameter int WORD_W = 12,
  parameter int ROT_W  = 4
) (
  input  logic [WORD_W-1:0] din,
  input  logic [ROT_W-1:0]  amt,
  output logic [WORD_W-1:0] dout
);
  logic [2*WORD_W-1:0] dbl;
  logic [ROT_W-1:0]    amt_c;

  assign dbl   = {din, din};
  assign amt_c = (int'(amt) > WORD_W - 1) ? '0 : amt;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign dout[i] = dbl[i + WORD_W - int'(amt_c)];
  end
endmodule

// File: rtl/lane_tap_sweeper.sv
module lane_tap_sweeper
  import lane_train_pkg::*;
#(
  parameter int WORD_W       = 12,
  parameter int TAP_W        = 5,
  parameter int SETTLE_WORDS = 8,
  parameter int HALF_EYE     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              raw_valid,
  input  logic [WORD_W-1:0] raw_data,
  output logic [TAP_W-1:0]  tap_sel,
  output logic [TAP_W-1:0]  eye_start,
  output logic [TAP_W-1:0]  eye_mid,
  output logic              edge_found,
  output logic              done,
  output logic              busy
);
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int CNT_W   = $clog2(SETTLE_WORDS + 1);

  sweep_state_t      state;
  logic [CNT_W-1:0]  settle_cnt;
  logic [WORD_W-1:0] prev_word;
  logic              first_tap;

  function automatic logic [TAP_W-1:0] mid_of(input logic [TAP_W-1:0] s);
    logic [TAP_W:0] sum;
    sum = {1'b0, s} + (TAP_W+1)'(HALF_EYE);
    if (sum > (TAP_W+1)'(TAP_MAX)) return TAP_W'(TAP_MAX);
    return sum[TAP_W-1:0];
  endfunction

  assign busy = (state != SW_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SW_IDLE;
      tap_sel    <= '0;
      eye_start  <= '0;
      eye_mid    <= '0;
      edge_found <= 1'b0;
      done       <= 1'b0;
      settle_cnt <= '0;
      prev_word  <= '0;
      first_tap  <= 1'b0;
    end else begin
      case (state)
        SW_IDLE: begin
          if (start) begin
            state      <= SW_SETTLE;
            tap_sel    <= '0;
            settle_cnt <= '0;
            first_tap  <= 1'b1;
            done       <= 1'b0;
            edge_found <= 1'b0;
          end
        end
        SW_SETTLE: begin
          if (raw_valid) begin
            if (settle_cnt == CNT_W'(SETTLE_WORDS - 1)) state <= SW_SAMPLE;
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        SW_SAMPLE: begin
          if (raw_valid) begin
            prev_word <= raw_data;
            if (!first_tap && raw_data != prev_word) begin
              eye_start  <= tap_sel;
              eye_mid    <= mid_of(tap_sel);
              tap_sel    <= mid_of(tap_sel);
              edge_found <= 1'b1;
              done       <= 1'b1;
              state      <= SW_IDLE;
            end else if (tap_sel == TAP_W'(TAP_MAX)) begin
              eye_start  <= '0;
              eye_mid    <= mid_of('0);
              tap_sel    <= mid_of('0);
              edge_found <= 1'b0;
              done       <= 1'b1;
              state      <= SW_IDLE;
            end else begin
              first_tap  <= 1'b0;
              tap_sel    <= tap_sel + 1'b1;
              settle_cnt <= '0;
              state      <= SW_SETTLE;
            end
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  // R3
  mid_not_below_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> eye_mid >= eye_start);
  // R3
  park_at_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tap_sel == eye_mid);
  // R2
  tap_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(tap_sel)) |-> tap_sel == $past(tap_sel) + 1'b1);
  // R4
  no_edge_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !edge_found) |-> (eye_start == '0 && eye_mid == mid_of('0)));
endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner
  import lane_train_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              edge_ok,
  input  logic              raw_valid,
  input  logic [WORD_W-1:0] raw_data,
  input  logic [WORD_W-1:0] train_word,
  output logic [ROT_W-1:0]  rot_count,
  output logic              done,
  output logic              ok
);
  align_state_t      state;
  logic [ROT_W-1:0]  trial;
  logic [WORD_W-1:0] trial_word;

  lane_rotator #(.WORD_W(WORD_W), .ROT_W(ROT_W)) u_trial_rot (
    .din (raw_data),
    .amt (trial),
    .dout(trial_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= AL_IDLE;
      trial     <= '0;
      rot_count <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
    end else begin
      case (state)
        AL_IDLE: begin
          if (start) begin
            state <= AL_TRY;
            trial <= '0;
            done  <= 1'b0;
            ok    <= 1'b0;
          end
        end
        AL_TRY: begin
          if (raw_valid) begin
            if (trial_word == train_word) begin
              rot_count <= trial;
              ok        <= edge_ok;
              done      <= 1'b1;
              state     <= AL_IDLE;
            end else if (trial == ROT_W'(WORD_W - 1)) begin
              rot_count <= '0;
              ok        <= 1'b0;
              done      <= 1'b1;
              state     <= AL_IDLE;
            end else begin
              trial <= trial + 1'b1;
            end
          end
        end
        default: state <= AL_IDLE;
      endcase
    end
  end

  // R5
  rot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rot_count) <= WORD_W - 1);
  // R6
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);
  // R9
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == AL_IDLE) |=> (!done && !ok));
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int WORD_W = 12,
  parameter int ROT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ROT_W-1:0]  rot,
  input  logic              raw_valid,
  output logic              raw_ready,
  input  logic [WORD_W-1:0] raw_data,
  output logic              cal_valid,
  input  logic              cal_ready,
  output logic [WORD_W-1:0] cal_data
);
  logic [WORD_W-1:0] rotated;
  logic              accept;

  lane_rotator #(.WORD_W(WORD_W), .ROT_W(ROT_W)) u_out_rot (
    .din (raw_data),
    .amt (rot),
    .dout(rotated)
  );

  assign raw_ready = !enable || !cal_valid || cal_ready;
  assign accept    = enable && raw_valid && raw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_valid <= 1'b0;
      cal_data  <= '0;
    end else if (!enable) begin
      cal_valid <= 1'b0;
    end else if (accept) begin
      cal_valid <= 1'b1;
      cal_data  <= rotated;
    end else if (cal_ready) begin
      cal_valid <= 1'b0;
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid && !cal_ready && enable) |=> (!enable || (cal_valid && $stable(cal_data))));
  // R7
  quiet_until_trained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !cal_valid);
endmodule

// File: rtl/lane_train_engine.sv
module lane_train_engine #(
  parameter int WORD_W       = 12,
  parameter int TAP_W        = 5,
  parameter int SETTLE_WORDS = 8,
  parameter int HALF_EYE     = 6,
  parameter int ROT_W        = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] train_word,
  input  logic              bit_start,
  input  logic              word_start,
  input  logic              raw_valid,
  output logic              raw_ready,
  input  logic [WORD_W-1:0] raw_data,
  output logic [TAP_W-1:0]  tap_sel,
  output logic [TAP_W-1:0]  eye_start,
  output logic [TAP_W-1:0]  eye_mid,
  output logic [ROT_W-1:0]  rot_count,
  output logic              bit_done,
  output logic              word_done,
  output logic              ok,
  output logic              cal_valid,
  input  logic              cal_ready,
  output logic [WORD_W-1:0] cal_data
);
  logic edge_found;
  logic sweep_busy;
  logic trained;

  lane_tap_sweeper #(
    .WORD_W(WORD_W), .TAP_W(TAP_W),
    .SETTLE_WORDS(SETTLE_WORDS), .HALF_EYE(HALF_EYE)
  ) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (bit_start),
    .raw_valid (raw_valid),
    .raw_data  (raw_data),
    .tap_sel   (tap_sel),
    .eye_start (eye_start),
    .eye_mid   (eye_mid),
    .edge_found(edge_found),
    .done      (bit_done),
    .busy      (sweep_busy)
  );

  lane_word_aligner #(.WORD_W(WORD_W), .ROT_W(ROT_W)) u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (word_start),
    .edge_ok   (edge_found),
    .raw_valid (raw_valid),
    .raw_data  (raw_data),
    .train_word(train_word),
    .rot_count (rot_count),
    .done      (word_done),
    .ok        (ok)
  );

  assign trained = ok && !sweep_busy && !bit_start && !word_start;

  lane_out_stage #(.WORD_W(WORD_W), .ROT_W(ROT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (trained),
    .rot      (rot_count),
    .raw_valid(raw_valid),
    .raw_ready(raw_ready),
    .raw_data (raw_data),
    .cal_valid(cal_valid),
    .cal_ready(cal_ready),
    .cal_data (cal_data)
  );

  // R8
  ready_while_untrained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> raw_ready);
endmodule

// File: tb/lane_train_engine_bench.sv
module lane_train_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] train_word = 12'h98E;
  logic        bit_start = 1'b0, word_start = 1'b0;
  logic        raw_valid = 1'b0, raw_ready;
  logic [11:0] raw_data = '0;
  logic [4:0]  tap_sel, eye_start, eye_mid;
  logic [3:0]  rot_count;
  logic        bit_done, word_done, ok, cal_valid;
  logic        cal_ready = 1'b1;
  logic [11:0] cal_data;

  int checks = 0, errors = 0;
  int m_edge = 5;
  logic [11:0] m_good = 12'h98E;
  logic m_override = 1'b0;

  always #5 clk = ~clk;

  lane_train_engine u_lane_train_engine (
    .clk(clk), .rst_n(rst_n), .train_word(train_word),
    .bit_start(bit_start), .word_start(word_start),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_data(raw_data),
    .tap_sel(tap_sel), .eye_start(eye_start), .eye_mid(eye_mid),
    .rot_count(rot_count), .bit_done(bit_done), .word_done(word_done),
    .ok(ok), .cal_valid(cal_valid), .cal_ready(cal_ready), .cal_data(cal_data)
  );

  function automatic logic [11:0] rotl(input logic [11:0] x, input int r);
    logic [11:0] y;
    for (int i = 0; i < 12; i++) y[(i + r) % 12] = x[i];
    return y;
  endfunction

  function automatic int exp_rot(input logic [11:0] w, input logic [11:0] t);
    for (int r = 0; r < 12; r++) if (rotl(w, r) == t) return r;
    return -1;
  endfunction

  function automatic int exp_mid(input int s);
    return (s + 6 > 31) ? 31 : s + 6;
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!m_override) begin
      raw_valid = ($urandom % 4) != 0;
      raw_data  = (int'(tap_sel) < m_edge) ? (m_good ^ 12'hA5A) : m_good;
    end
  endtask

  task automatic pulse(input bit which_bit);
    if (which_bit) bit_start = 1'b1; else word_start = 1'b1;
    step();
    bit_start = 1'b0;
    word_start = 1'b0;
  endtask

  task automatic run_cal(input logic [11:0] tw, input logic [11:0] lane, input int edge_t,
                         input int slip, input string tag);
    int exp_s, exp_m, er;
    bit found;
    train_word = tw;
    m_edge = edge_t;
    m_good = rotl(lane, (12 - slip) % 12);
    pulse(1'b1);
    // R9: start clears bit_done
    chk(!bit_done, "R9 bit_done cleared", int'(bit_done), 0);
    for (int n = 0; n < 4000 && !bit_done; n++) step();
    found = (edge_t >= 1 && edge_t <= 31);
    exp_s = found ? edge_t : 0;
    exp_m = exp_mid(exp_s);
    chk(bit_done, {tag, " R3 bit_done"}, int'(bit_done), 1);
    if (found) chk(eye_start == 5'(exp_s), {tag, " R2 eye_start"}, int'(eye_start), exp_s);
    else chk(eye_start == 5'(exp_s), {tag, " R4 eye_start"}, int'(eye_start), exp_s);
    chk(eye_mid == 5'(exp_m), {tag, " R3 eye_mid"}, int'(eye_mid), exp_m);
    chk(tap_sel == 5'(exp_m), {tag, " R3 tap park"}, int'(tap_sel), exp_m);
    pulse(1'b0);
    chk(!word_done && !ok, "R9 word_done cleared", int'(word_done), 0);
    for (int n = 0; n < 200 && !word_done; n++) step();
    er = exp_rot(m_good, tw);
    chk(word_done, {tag, " R5 word_done"}, int'(word_done), 1);
    if (er >= 0) begin
      chk(rot_count == 4'(er), {tag, " R5 rot_count"}, int'(rot_count), er);
      chk(ok == found, {tag, " R5/R4 ok"}, int'(ok), int'(found));
    end else begin
      chk(rot_count == 4'd0, {tag, " R6 rot_count"}, int'(rot_count), 0);
      chk(!ok, {tag, " R6 ok"}, int'(ok), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] w1, w2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tap_sel == 0 && eye_start == 0 && eye_mid == 0, "R1 taps", int'(tap_sel), 0);
    chk(rot_count == 0, "R1 rot_count", int'(rot_count), 0);
    chk(!bit_done && !word_done && !ok && !cal_valid, "R1 flags",
        int'({bit_done, word_done, ok, cal_valid}), 0);
    chk(raw_ready, "R1 raw_ready", int'(raw_ready), 1);
    rst_n = 1'b1;
    step();
    // R7: no output before training
    raw_valid = 1'b1;
    step();
    chk(!cal_valid, "R7 no output untrained", int'(cal_valid), 0);
    chk(raw_ready, "R8 ready untrained", int'(raw_ready), 1);

    run_cal(12'h98E, 12'h98E, 30, 0, "edge30");
    run_cal(12'h98E, 12'h98E, 0, 3, "noedge");
    run_cal(12'hFFF, 12'h98E, 4, 2, "nomatch");
    run_cal(12'h98E, 12'h98E, 31, 11, "edge31");
    for (int k = 0; k < 6; k++)
      run_cal(12'h98E, 12'h98E, 1 + int'($urandom % 25), int'($urandom % 12), "rand");
    for (int k = 0; k < 3; k++) begin
      logic [11:0] tw;
      tw = 12'($urandom);
      run_cal(tw, tw, 1 + int'($urandom % 28), int'($urandom % 12), "randword");
    end

    // R7/R8: streaming after a successful run
    run_cal(12'h98E, 12'h98E, 7, 5, "stream");
    m_override = 1'b1;
    w1 = 12'h3C5; w2 = 12'hA17;
    @(negedge clk);
    cal_ready = 1'b1; raw_valid = 1'b1; raw_data = w1;
    @(negedge clk);
    chk(cal_valid && cal_data == rotl(w1, int'(rot_count)), "R7 stream word",
        int'(cal_data), int'(rotl(w1, int'(rot_count))));
    cal_ready = 1'b0; raw_data = w2;
    #1;
    chk(!raw_ready, "R8 ready low on stall", int'(raw_ready), 0);
    @(negedge clk);
    chk(cal_valid && cal_data == rotl(w1, int'(rot_count)), "R8 hold on stall",
        int'(cal_data), int'(rotl(w1, int'(rot_count))));
    cal_ready = 1'b1;
    @(negedge clk);
    chk(cal_valid && cal_data == rotl(w2, int'(rot_count)), "R8 resume",
        int'(cal_data), int'(rotl(w2, int'(rot_count))));
    raw_valid = 1'b0;
    @(negedge clk);
    chk(!cal_valid, "R7 drained", int'(cal_valid), 0);
    m_override = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule